// File: doc/BRIEF.md
# Shadow-Bit Page Color Renamer

This unit rewrites addresses between a core's TLB and the shared L2 path so that a page can be moved to a different cache color without copying it in memory. In the inbound (on-chip) direction it takes a real physical address together with the TLB entry's optional new color. When that color is valid, the unit puts it into the page color field. It stores the displaced original color in the top shadow bits, which every real address leaves at zero, and sets a marker bit just below them. The result is an internal name that no real address can equal, and two internal names can only be equal if their real addresses are equal.

In the outbound (off-chip) direction the unit turns an internal name back into the real physical address without any table. It copies the stored original color back into the color field and zeroes the whole shadow region. An inbound access to a page whose migration is still in progress is not forwarded. Instead the unit raises a stall flag, so the core waits only on such pages. Both directions register their result once, so each has a latency of one clock.

The color width, the color field position, the real address width and the address width are parameters. The defaults are a 64-bit address with 41 real bits, a 6-bit color at bits [17:12], the stored color at [63:58] and the marker at bit 57. The color field must lie above the page offset, so the L1 can keep indexing with virtual address bits.

Top module: `color_rename_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ren_valid_o`, `ren_stall_o` and `ret_valid_o` are 0 after that edge.
- R2: An inbound request with `ren_npc_valid_i`=1 and no migration gives, one clock later with `ren_valid_o`=1, the input address with bits [17:12] replaced by `ren_npc_i`, bits [63:58] holding the input's bits [17:12], bit 57 set, and all other bits unchanged.
- R3: An inbound request with `ren_npc_valid_i`=0 and no migration gives, one clock later with `ren_valid_o`=1, the input address unchanged.
- R4: An inbound request with `ren_migrating_i`=1 gives, one clock later, `ren_stall_o`=1 and `ren_valid_o`=0, whatever the color inputs are.
- R5: An outbound request gives, one clock later with `ret_valid_o`=1, the input address with bits [63:41] cleared and, only when bit 57 is set, bits [17:12] taken from the input's bits [63:58].
- R6: An outbound address whose bits [63:41] are all zero leaves the unit unchanged.
- R7: Restoring the renamed form of any real address (bits [63:41] zero) with any new color yields that address again.
- R8: A renamed address has at least one nonzero bit in [63:41], even when the original color is 0.
- R9: With `ren_valid_i` and `ret_valid_i` low, `ren_valid_o`, `ren_stall_o` and `ret_valid_o` are 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid_i | input | 1 | Inbound request present |
| ren_paddr_i | input | 64 | Real physical address from the TLB |
| ren_npc_valid_i | input | 1 | TLB entry holds a new color |
| ren_npc_i | input | 6 | New color for the page |
| ren_migrating_i | input | 1 | Page migration is in progress |
| ren_valid_o | output | 1 | Internal address is valid |
| ren_stall_o | output | 1 | Request held because its page is migrating |
| ren_addr_o | output | 64 | Internal address toward L1/L2 |
| ret_valid_i | input | 1 | Outbound request present |
| ret_addr_i | input | 64 | Internal address leaving the chip |
| ret_valid_o | output | 1 | Restored address is valid |
| ret_addr_o | output | 64 | Real physical address |

## Verification
A wrong swap in the inbound path shows up one clock after the request. The color field holds the wrong value, or the shadow field does not hold the original color, or the marker is missing. A missing marker means a renamed page with original color 0 becomes indistinguishable from a real address. A wrong outbound path shows up one clock later as leftover shadow bits or a stale color. It also breaks the round trip on a random pair at once, because the restored address differs from the address that went in. A faulty classification register shows up on the very next clock as a valid and stall pair that disagrees with the migrating input.

// File: rtl/crn_pkg.sv
// Shared types for the shadow-bit color renamer.
// Assumes: nothing beyond SystemVerilog packed types.
package crn_pkg;
    // Outcome of an inbound request, held one cycle in the rename stage.
    typedef enum logic [1:0] {
        XLATE_IDLE    = 2'd0,
        XLATE_PASS    = 2'd1,
        XLATE_RENAMED = 2'd2,
        XLATE_HELD    = 2'd3
    } xlate_kind_e;

    localparam int KIND_W = $bits(xlate_kind_e);
endpackage

// File: rtl/crn_pipe_reg.sv
// Plain pipeline register with synchronous active-low reset to zero.
// Assumes: W >= 1; the caller packs valid/kind bits so that zero means idle.
module crn_pipe_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture d each cycle; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/crn_rename_stage.sv
// Inbound stage: swaps a new page color into a real address and parks the
// original color plus a marker bit in the shadow region; classifies the
// request as pass, renamed or held (page migrating). One cycle latency.
// Assumes: input addresses are real, i.e. their shadow bits are zero.
module crn_rename_stage
    import crn_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int COLOR_W   = 6,
    parameter int COLOR_LSB = 12,
    parameter int SH_LO     = 58,
    parameter int MARK_BIT  = 57
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [ADDR_W-1:0]  paddr_i,
    input  logic               npc_valid_i,
    input  logic [COLOR_W-1:0] npc_i,
    input  logic               migrating_i,
    output logic               valid_o,
    output logic               stall_o,
    output logic [ADDR_W-1:0]  addr_o
);
    localparam int REG_W = KIND_W + ADDR_W;

    logic [ADDR_W-1:0] named;
    xlate_kind_e       kind_d;
    xlate_kind_e       kind_q;
    logic [REG_W-1:0]  stage_d;
    logic [REG_W-1:0]  stage_q;

    // Build the internal name and classify the request.
    always_comb begin
        named  = paddr_i;
        kind_d = XLATE_IDLE;
        if (npc_valid_i) begin
            named[COLOR_LSB +: COLOR_W] = npc_i;
            named[SH_LO +: COLOR_W]     = paddr_i[COLOR_LSB +: COLOR_W];
            named[MARK_BIT]             = 1'b1;
        end
        if (valid_i) begin
            if (migrating_i)      kind_d = XLATE_HELD;
            else if (npc_valid_i) kind_d = XLATE_RENAMED;
            else                  kind_d = XLATE_PASS;
        end
    end

    assign stage_d = {kind_d, named};

    crn_pipe_reg #(.W(REG_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stage_d),
        .q     (stage_q)
    );

    // Decode the registered classification into the output flags.
    always_comb begin
        kind_q  = xlate_kind_e'(stage_q[REG_W-1 -: KIND_W]);
        valid_o = (kind_q == XLATE_PASS) || (kind_q == XLATE_RENAMED);
        stall_o = (kind_q == XLATE_HELD);
        addr_o  = stage_q[ADDR_W-1:0];
    end
endmodule

// File: rtl/crn_restore_stage.sv
// Outbound stage: turns an internal name back into the real address by
// copying the parked color home (when the marker is set) and zeroing the
// shadow region. No table lookup. One cycle latency.
// Assumes: the shadow region is bits [ADDR_W-1:PHYS_W].
module crn_restore_stage #(
    parameter int ADDR_W    = 64,
    parameter int PHYS_W    = 41,
    parameter int COLOR_W   = 6,
    parameter int COLOR_LSB = 12,
    parameter int SH_LO     = 58,
    parameter int MARK_BIT  = 57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int REG_W = 1 + ADDR_W;

    logic [ADDR_W-1:0] fixed;
    logic [REG_W-1:0]  stage_q;

    // Restore the color field and clear every shadow bit.
    always_comb begin
        fixed = addr_i;
        if (addr_i[MARK_BIT]) fixed[COLOR_LSB +: COLOR_W] = addr_i[SH_LO +: COLOR_W];
        fixed[ADDR_W-1:PHYS_W] = '0;
    end

    crn_pipe_reg #(.W(REG_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({valid_i, fixed}),
        .q     (stage_q)
    );

    assign valid_o = stage_q[REG_W-1];
    assign addr_o  = stage_q[ADDR_W-1:0];
endmodule

// File: rtl/color_rename_unit.sv
// Top: page color renamer between a core TLB and the shared L2 path.
// Inbound requests get an internal name when the TLB entry holds a new
// color; outbound requests get their real address back. Both paths are
// independent and registered once.
// Assumes: the color field sits above the page offset and inside the real
// address bits; the parked color and marker fit inside the shadow region.
module color_rename_unit #(
    parameter int ADDR_W     = 64,
    parameter int PHYS_W     = 41,
    parameter int COLOR_W    = 6,
    parameter int COLOR_LSB  = 12,
    parameter int PAGE_OFF_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ren_valid_i,
    input  logic [ADDR_W-1:0]  ren_paddr_i,
    input  logic               ren_npc_valid_i,
    input  logic [COLOR_W-1:0] ren_npc_i,
    input  logic               ren_migrating_i,
    output logic               ren_valid_o,
    output logic               ren_stall_o,
    output logic [ADDR_W-1:0]  ren_addr_o,
    input  logic               ret_valid_i,
    input  logic [ADDR_W-1:0]  ret_addr_i,
    output logic               ret_valid_o,
    output logic [ADDR_W-1:0]  ret_addr_o
);
    localparam int SH_LO    = ADDR_W - COLOR_W;
    localparam int MARK_BIT = SH_LO - 1;

    // Reject layouts that would touch L1 index bits or overlap real bits.
    generate
        if (COLOR_LSB < PAGE_OFF_W || COLOR_LSB + COLOR_W > PHYS_W || MARK_BIT < PHYS_W) begin : g_bad_cfg
            $error("color_rename_unit: illegal color or shadow field layout");
        end
    endgenerate

    crn_rename_stage #(
        .ADDR_W    (ADDR_W),
        .COLOR_W   (COLOR_W),
        .COLOR_LSB (COLOR_LSB),
        .SH_LO     (SH_LO),
        .MARK_BIT  (MARK_BIT)
    ) u_rename (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (ren_valid_i),
        .paddr_i     (ren_paddr_i),
        .npc_valid_i (ren_npc_valid_i),
        .npc_i       (ren_npc_i),
        .migrating_i (ren_migrating_i),
        .valid_o     (ren_valid_o),
        .stall_o     (ren_stall_o),
        .addr_o      (ren_addr_o)
    );

    crn_restore_stage #(
        .ADDR_W    (ADDR_W),
        .PHYS_W    (PHYS_W),
        .COLOR_W   (COLOR_W),
        .COLOR_LSB (COLOR_LSB),
        .SH_LO     (SH_LO),
        .MARK_BIT  (MARK_BIT)
    ) u_restore (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (ret_valid_i),
        .addr_i  (ret_addr_i),
        .valid_o (ret_valid_o),
        .addr_o  (ret_addr_o)
    );
endmodule

// File: rtl/crn_checker.sv
// Port-level properties of color_rename_unit, attached with bind below.
// Assumes: one-cycle latency on both paths, as the top module documents.
module crn_checker #(
    parameter int ADDR_W    = 64,
    parameter int PHYS_W    = 41,
    parameter int COLOR_W   = 6,
    parameter int COLOR_LSB = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ren_valid_i,
    input logic [ADDR_W-1:0]  ren_paddr_i,
    input logic               ren_npc_valid_i,
    input logic [COLOR_W-1:0] ren_npc_i,
    input logic               ren_migrating_i,
    input logic               ren_valid_o,
    input logic               ren_stall_o,
    input logic [ADDR_W-1:0]  ren_addr_o,
    input logic               ret_valid_i,
    input logic [ADDR_W-1:0]  ret_addr_i,
    input logic               ret_valid_o,
    input logic [ADDR_W-1:0]  ret_addr_o
);
    localparam int SH_LO = ADDR_W - COLOR_W;

    // R1: reset clears every valid and stall output.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!ren_valid_o && !ren_stall_o && !ret_valid_o));

    // R2: a renamed result carries the new color and the parked old color.
    assert_rename_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid_o && $past(ren_npc_valid_i)) |->
        (ren_addr_o[COLOR_LSB +: COLOR_W] == $past(ren_npc_i) &&
         ren_addr_o[SH_LO +: COLOR_W] == $past(ren_paddr_i[COLOR_LSB +: COLOR_W])));

    // R3: without a new color the address is forwarded untouched.
    assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid_o && !$past(ren_npc_valid_i)) |-> ren_addr_o == $past(ren_paddr_i));

    // R4: a migrating page stalls and is not forwarded.
    assert_migrating_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid_i && ren_migrating_i) |=> (ren_stall_o && !ren_valid_o));

    // R5: restored addresses have no shadow bits.
    assert_shadow_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid_o |-> ret_addr_o[ADDR_W-1:PHYS_W] == '0);

    // R6: real addresses pass the restore path unchanged.
    assert_restore_identity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_o && $past(ret_addr_i[ADDR_W-1:PHYS_W]) == '0) |-> ret_addr_o == $past(ret_addr_i));

    // R8: a renamed address never looks like a real one.
    assert_unique_name_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid_o && $past(ren_npc_valid_i)) |-> ren_addr_o[ADDR_W-1:PHYS_W] != '0);

    // R9: no request in, no valid or stall out.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren_valid_i && !ret_valid_i) |=> (!ren_valid_o && !ren_stall_o && !ret_valid_o));
endmodule

bind color_rename_unit crn_checker #(
    .ADDR_W    (ADDR_W),
    .PHYS_W    (PHYS_W),
    .COLOR_W   (COLOR_W),
    .COLOR_LSB (COLOR_LSB)
) u_crn_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .ren_valid_i     (ren_valid_i),
    .ren_paddr_i     (ren_paddr_i),
    .ren_npc_valid_i (ren_npc_valid_i),
    .ren_npc_i       (ren_npc_i),
    .ren_migrating_i (ren_migrating_i),
    .ren_valid_o     (ren_valid_o),
    .ren_stall_o     (ren_stall_o),
    .ren_addr_o      (ren_addr_o),
    .ret_valid_i     (ret_valid_i),
    .ret_addr_i      (ret_addr_i),
    .ret_valid_o     (ret_valid_o),
    .ret_addr_o      (ret_addr_o)
);

// File: tb/color_rename_unit_test.sv
`timescale 1ns/1ps
// Directed bench for color_rename_unit: one task per scenario.
module color_rename_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ren_valid_i = 1'b0;
    logic [63:0] ren_paddr_i = '0;
    logic        ren_npc_valid_i = 1'b0;
    logic [5:0]  ren_npc_i = '0;
    logic        ren_migrating_i = 1'b0;
    logic        ren_valid_o;
    logic        ren_stall_o;
    logic [63:0] ren_addr_o;
    logic        ret_valid_i = 1'b0;
    logic [63:0] ret_addr_i = '0;
    logic        ret_valid_o;
    logic [63:0] ret_addr_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    color_rename_unit uut (
        .clk(clk), .rst_n(rst_n),
        .ren_valid_i(ren_valid_i), .ren_paddr_i(ren_paddr_i),
        .ren_npc_valid_i(ren_npc_valid_i), .ren_npc_i(ren_npc_i),
        .ren_migrating_i(ren_migrating_i),
        .ren_valid_o(ren_valid_o), .ren_stall_o(ren_stall_o), .ren_addr_o(ren_addr_o),
        .ret_valid_i(ret_valid_i), .ret_addr_i(ret_addr_i),
        .ret_valid_o(ret_valid_o), .ret_addr_o(ret_addr_o)
    );

    localparam logic [63:0] REAL_MASK = 64'h0000_01FF_FFFF_FFFF;

    // Expected internal name, from R2.
    function automatic logic [63:0] exp_rename(input logic [63:0] a, input logic [5:0] c);
        logic [63:0] r = a;
        r[17:12] = c;
        r[63:58] = a[17:12];
        r[57]    = 1'b1;
        return r;
    endfunction

    // Expected real address, from R5.
    function automatic logic [63:0] exp_restore(input logic [63:0] a);
        logic [63:0] r = a;
        if (a[57]) r[17:12] = a[63:58];
        r[63:41] = '0;
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one inbound request and return the registered result.
    task automatic send_in(input logic [63:0] a, input logic nv, input logic [5:0] c,
                           input logic mig, output logic [63:0] res,
                           output logic v, output logic s);
        @(negedge clk);
        ren_valid_i = 1'b1; ren_paddr_i = a; ren_npc_valid_i = nv;
        ren_npc_i = c; ren_migrating_i = mig;
        @(negedge clk);
        ren_valid_i = 1'b0; ren_npc_valid_i = 1'b0; ren_migrating_i = 1'b0;
        res = ren_addr_o; v = ren_valid_o; s = ren_stall_o;
    endtask

    // Present one outbound request and return the registered result.
    task automatic send_out(input logic [63:0] a, output logic [63:0] res, output logic v);
        @(negedge clk);
        ret_valid_i = 1'b1; ret_addr_i = a;
        @(negedge clk);
        ret_valid_i = 1'b0;
        res = ret_addr_o; v = ret_valid_o;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        ren_valid_i = 1'b1; ret_valid_i = 1'b1;
        @(negedge clk);
        check("R1 ren_valid", {63'd0, ren_valid_o}, 64'd0);
        check("R1 ren_stall", {63'd0, ren_stall_o}, 64'd0);
        check("R1 ret_valid", {63'd0, ret_valid_o}, 64'd0);
        ren_valid_i = 1'b0; ret_valid_i = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_rename();
        logic [63:0] r; logic v, s;
        logic [63:0] a = 64'h0000_0123_4567_A9BC;
        send_in(a, 1'b1, 6'h15, 1'b0, r, v, s);
        check("R2 valid", {63'd0, v}, 64'd1);
        check("R2 addr", r, exp_rename(a, 6'h15));
        // Original color zero: marker must still make the name unique.
        a = 64'h0000_0000_0000_0040;
        send_in(a, 1'b1, 6'h3F, 1'b0, r, v, s);
        check("R8 addr", r, exp_rename(a, 6'h3F));
        check("R8 shadow nonzero", {63'd0, (r[63:41] != 23'd0)}, 64'd1);
    endtask

    task automatic t_passthrough();
        logic [63:0] r; logic v, s;
        logic [63:0] a = 64'h0000_01AB_CDEF_F123;
        send_in(a, 1'b0, 6'h2A, 1'b0, r, v, s);
        check("R3 valid", {63'd0, v}, 64'd1);
        check("R3 addr", r, a);
    endtask

    task automatic t_migrating();
        logic [63:0] r; logic v, s;
        send_in(64'h0000_0000_1234_5000, 1'b1, 6'h01, 1'b1, r, v, s);
        check("R4 stall", {63'd0, s}, 64'd1);
        check("R4 valid", {63'd0, v}, 64'd0);
        send_in(64'h0000_0000_1234_5000, 1'b0, 6'h00, 1'b1, r, v, s);
        check("R4 stall no npc", {63'd0, s}, 64'd1);
    endtask

    task automatic t_restore();
        logic [63:0] r; logic v;
        logic [63:0] a = {6'h2D, 1'b1, 16'h0000, 41'h0_1111_2_3F_ABC};
        send_out(a, r, v);
        check("R5 valid", {63'd0, v}, 64'd1);
        check("R5 addr", r, exp_restore(a));
        // Shadow bits set without marker: only cleared, color kept.
        a = {6'h11, 1'b0, 16'h0001, 41'h0_0000_0_05_123};
        send_out(a, r, v);
        check("R5 no marker", r, exp_restore(a));
        a = 64'h0000_01FF_FFFF_F000;
        send_out(a, r, v);
        check("R6 identity", r, a);
    endtask

    task automatic t_round_trip();
        logic [63:0] r1, r2, a; logic v, s;
        for (int i = 0; i < 20; i++) begin
            a = {$urandom, $urandom} & REAL_MASK;
            send_in(a, 1'b1, 6'($urandom), 1'b0, r1, v, s);
            send_out(r1, r2, v);
            check("R7 round trip", r2, a);
        end
    endtask

    task automatic t_idle();
        @(negedge clk);
        @(negedge clk);
        check("R9 ren_valid", {63'd0, ren_valid_o}, 64'd0);
        check("R9 ren_stall", {63'd0, ren_stall_o}, 64'd0);
        check("R9 ret_valid", {63'd0, ret_valid_o}, 64'd0);
    endtask

    initial begin
        t_reset();
        t_rename();
        t_passthrough();
        t_migrating();
        t_restore();
        t_round_trip();
        t_idle();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule